// File: doc/BRIEF.md
# 100BASE-TX Transmit Symbol Encoder

This block turns the nibble stream a MAC presents on a media-independent transmit interface into the ternary line-symbol stream of a 100 Mb/s twisted-pair link. It runs from a single symbol-rate clock (125 MHz). It divides that clock by five to produce the nibble clock it hands back to the MAC, and it samples `tx_en` and `txd` once per nibble period.

Each sampled nibble becomes one 5-bit code group. When a frame starts, the block sends a start delimiter pair in place of the first preamble octet. When `tx_en` drops, it appends an end delimiter pair. Between frames it sends idle groups continuously. The groups are serialized most significant bit first and XORed with a free-running 11-bit side-stream scrambler key. The scrambled bits then drive an MLT-3 level machine whose three levels are output as a 2-bit code.

A downstream analog driver turns `sym` into line voltages. A receiver that locks onto the scrambler during idle can recover every code group from `sym` alone.

Top module: `ptx_encoder`

## Requirements
- R1: `tx_clk` has a period of five `clk_sym` cycles: high for 2 cycles, then low for 3. `tx_en` and `txd` are sampled at the `clk_sym` edge at which `tx_clk` rises.
- R2: The first two nibbles of a frame, which form the first preamble octet, are replaced by J = 11000 and then K = 10001, whatever their value.
- R3: The first nibble period in which `tx_en` is sampled low ends the frame. The block then sends T = 01101 followed by R = 00111.
- R4: Every later nibble of the frame is sent as its 4B/5B data group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: Outside frames the idle group 11111 is sent continuously. If `tx_en` is still low at the sample after R, an idle group follows R.
- R6: Code group bits leave most significant bit first. Each bit is XORed with key = s[10]^s[8] of an 11-bit register s (polynomial x^11 + x^9 + 1). On every symbol, s shifts left and the key enters at s[0]. s is loaded with the nonzero `LFSR_SEED` at reset.
- R7: MLT-3 output: a scrambled 1 advances the level one step around the cycle 0, +1, 0, −1, and a 0 holds it. `sym` encodes 0 as 00, +1 as 01 and −1 as 11. The value 10 never occurs, and the level never jumps directly between +1 and −1.
- R8: During reset `sym` is 00 and `tx_clk` is high.
- R9: A frame whose `tx_en` covers only the two preamble-octet nibbles produces J, K, T, R with no data group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sym | input | 1 | Symbol-rate clock, 125 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame-valid from the MAC, sampled once per nibble |
| txd | input | 4 | Transmit nibble from the MAC |
| tx_clk | output | 1 | Nibble clock to the MAC, `clk_sym` divided by 5 |
| sym | output | 2 | MLT-3 level: 00 zero, 01 plus, 11 minus |

## Verification
The bench recovers the stream the way a receiver would. It learns the scrambler from idle, descrambles the MLT-3 transitions and aligns on the J/K window. It then compares every group against the scoreboard. Several cases are aimed at specific faults:
- Preamble nibbles other than 5 expose a design that encodes the preamble instead of substituting the delimiters.
- A frame with no payload catches a design that inserts a data group or drops T/R.
- Sending all sixteen nibble values exposes any wrong entry in the code table.
- Idle checks before the first frame and after each R catch a wrong scrambler tap, seed handling or bit order, since these turn idle into non-ones.
- A wrong level sequence breaks the transition recovery, and a direct ±1 jump is counted explicitly.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   localparam int NIB_W = 4;
   localparam int CG_W  = 5;
   localparam int CNT_W = $clog2(CG_W);

   typedef logic [CG_W-1:0] cg_t;

   localparam cg_t CG_IDLE = 5'b11111;
   localparam cg_t CG_J    = 5'b11000;
   localparam cg_t CG_K    = 5'b10001;
   localparam cg_t CG_T    = 5'b01101;
   localparam cg_t CG_R    = 5'b00111;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SSD2 = 2'd1,
      FR_DATA = 2'd2,
      FR_ESD2 = 2'd3
   } fr_state_t;

   typedef enum logic [1:0] {
      LVL_ZERO = 2'b00,
      LVL_POS  = 2'b01,
      LVL_NEG  = 2'b11
   } lvl_t;

   function automatic cg_t nib_to_cg(input logic [NIB_W-1:0] n);
      cg_t c;
      unique case (n)
         4'h0: c = 5'b11110;
         4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;
         4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;
         4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;
         4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;
         4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;
         4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;
         4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ptx_framer.sv
module ptx_framer
   import ptx_pkg::*;
#(
   parameter int CLK_HIGH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic [NIB_W-1:0] txd,
   output logic             tx_clk,
   output logic             grp_ld,
   output cg_t              grp_q,
   output logic             plain
);

   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CG_W - 1);
   localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(CLK_HIGH);

   logic [CNT_W-1:0] cnt_q;
   fr_state_t        st_q, st_d;
   cg_t              grp_d;

   assign grp_ld = (cnt_q == LAST_C);
   assign tx_clk = (cnt_q < HIGH_C);
   assign plain  = grp_q[LAST_C - cnt_q];

   always_comb begin
      st_d  = st_q;
      grp_d = grp_q;
      unique case (st_q)
         FR_IDLE: begin
            if (tx_en) begin
               grp_d = CG_J;
               st_d  = FR_SSD2;
            end else begin
               grp_d = CG_IDLE;
            end
         end
         FR_SSD2: begin
            grp_d = CG_K;
            st_d  = FR_DATA;
         end
         FR_DATA: begin
            if (tx_en) begin
               grp_d = nib_to_cg(txd);
            end else begin
               grp_d = CG_T;
               st_d  = FR_ESD2;
            end
         end
         default: begin
            grp_d = CG_R;
            st_d  = FR_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         st_q  <= FR_IDLE;
         grp_q <= CG_IDLE;
      end else begin
         cnt_q <= grp_ld ? '0 : cnt_q + 1'b1;
         if (grp_ld) begin
            st_q  <= st_d;
            grp_q <= grp_d;
         end
      end
   end

endmodule

// File: rtl/ptx_scrambler.sv
module ptx_scrambler #(
   parameter int LEN    = 11,
   parameter int TAP    = 9,
   parameter int SEED   = 11'h2A5,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic plain,
   output logic scr_q
);

   generate
      if (ENABLE) begin : g_scr
         logic [LEN-1:0] lfsr_q;
         logic           key;

         assign key = lfsr_q[LEN-1] ^ lfsr_q[TAP-1];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lfsr_q <= LEN'(SEED);
               scr_q  <= 1'b0;
            end else begin
               lfsr_q <= {lfsr_q[LEN-2:0], key};
               scr_q  <= plain ^ key;
            end
         end
      end else begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) scr_q <= 1'b0;
            else        scr_q <= plain;
         end
      end
   endgenerate

endmodule

// File: rtl/ptx_mlt3.sv
module ptx_mlt3
   import ptx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_in,
   output logic [1:0] sym
);

   logic [1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= 2'd0;
      else        phase_q <= phase_q + {1'b0, bit_in};
   end

   always_comb begin
      unique case (phase_q)
         2'd1:    sym = LVL_POS;
         2'd3:    sym = LVL_NEG;
         default: sym = LVL_ZERO;
      endcase
   end

endmodule

// File: rtl/ptx_encoder.sv
module ptx_encoder
   import ptx_pkg::*;
#(
   parameter int LFSR_LEN  = 11,
   parameter int LFSR_TAP  = 9,
   parameter int LFSR_SEED = 11'h2A5,
   parameter bit SCRAMBLE  = 1'b1,
   parameter int CLK_HIGH  = 2
) (
   input  logic       clk_sym,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic [3:0] txd,
   output logic       tx_clk,
   output logic [1:0] sym
);

   if (LFSR_SEED == 0) begin : g_bad_seed
      $error("ptx_encoder: LFSR_SEED must be nonzero");
   end
   if (LFSR_TAP < 1 || LFSR_TAP >= LFSR_LEN) begin : g_bad_tap
      $error("ptx_encoder: LFSR_TAP must lie below LFSR_LEN");
   end
   if (CLK_HIGH < 1 || CLK_HIGH >= CG_W) begin : g_bad_high
      $error("ptx_encoder: CLK_HIGH must be 1..4");
   end

   logic grp_ld;
   cg_t  grp_q;
   logic plain;
   logic scr_q;

   ptx_framer #(.CLK_HIGH(CLK_HIGH)) u_framer (
      .clk    (clk_sym),
      .rst_n  (rst_n),
      .tx_en  (tx_en),
      .txd    (txd),
      .tx_clk (tx_clk),
      .grp_ld (grp_ld),
      .grp_q  (grp_q),
      .plain  (plain)
   );

   ptx_scrambler #(
      .LEN    (LFSR_LEN),
      .TAP    (LFSR_TAP),
      .SEED   (LFSR_SEED),
      .ENABLE (SCRAMBLE)
   ) u_scr (
      .clk   (clk_sym),
      .rst_n (rst_n),
      .plain (plain),
      .scr_q (scr_q)
   );

   ptx_mlt3 u_mlt3 (
      .clk    (clk_sym),
      .rst_n  (rst_n),
      .bit_in (scr_q),
      .sym    (sym)
   );

endmodule

// File: rtl/ptx_checker.sv
module ptx_checker
   import ptx_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tx_clk,
   input logic [1:0] sym,
   input logic       ld,
   input cg_t        grp
);

   logic       tx_d, seen, ld_d;
   logic [3:0] gap;
   cg_t        prev_grp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_d     <= 1'b1;
         seen     <= 1'b0;
         gap      <= 4'd0;
         ld_d     <= 1'b0;
         prev_grp <= CG_IDLE;
      end else begin
         tx_d <= tx_clk;
         ld_d <= ld;
         if (tx_clk && !tx_d) begin
            seen <= 1'b1;
            gap  <= 4'd1;
         end else if (gap != 4'hF) begin
            gap <= gap + 4'd1;
         end
         if (ld) prev_grp <= grp;
      end
   end

   assert_clk_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_clk && !tx_d && seen) |-> (gap == 4'(CG_W)));

   assert_sym_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sym != 2'b10);

   assert_no_jump_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sym == LVL_POS) |=> (sym != LVL_NEG));

   assert_no_jump_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sym == LVL_NEG) |=> (sym != LVL_POS));

   assert_k_after_j_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_d && grp == CG_K) |-> (prev_grp == CG_J));

   assert_r_after_t_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_d && grp == CG_R) |-> (prev_grp == CG_T));

   assert_t_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_d && grp == CG_T) |->
      (prev_grp != CG_IDLE && prev_grp != CG_R && prev_grp != CG_T && prev_grp != CG_J));

   assert_j_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_d && grp == CG_J) |-> (prev_grp == CG_IDLE || prev_grp == CG_R));

endmodule

bind ptx_encoder ptx_checker u_chk (
   .clk    (clk_sym),
   .rst_n  (rst_n),
   .tx_clk (tx_clk),
   .sym    (sym),
   .ld     (grp_ld),
   .grp    (grp_q)
);

// File: tb/test_ptx_encoder.sv
module test_ptx_encoder;

   localparam int CLK_PERIOD = 8;

   logic       clk_sym = 1'b0;
   logic       rst_n   = 1'b0;
   logic       tx_en   = 1'b0;
   logic [3:0] txd     = 4'h0;
   logic       tx_clk;
   logic [1:0] sym;

   int checks = 0;
   int errors = 0;

   logic [4:0] code_tab [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                 5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                 5'b11010, 5'b11011, 5'b11100, 5'b11101};
   localparam logic [4:0] G_J = 5'b11000, G_K = 5'b10001;
   localparam logic [4:0] G_T = 5'b01101, G_R = 5'b00111, G_I = 5'b11111;

   logic [4:0] exp_q [$];

   always #(CLK_PERIOD/2) clk_sym = ~clk_sym;

   ptx_encoder i_ptx_encoder (
      .clk_sym (clk_sym),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .txd     (txd),
      .tx_clk  (tx_clk),
      .sym     (sym)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- monitor: receiver model ----------------
   logic [1:0]  prev_sym = 2'b00;
   logic [10:0] hist = '0;
   logic [9:0]  win = '1;
   logic [4:0]  acc = '0;
   int nbits = 0, idle_bad = 0, mlt_bad = 0, mstate = 0, bcnt = 0;
   int frames_seen = 0, empty_frames = 0, data_in_frame = 0;

   always @(negedge clk_sym) begin
      if (rst_n) begin
         logic b, key, p;
         logic [4:0] e;
         b = (sym != prev_sym);
         if (sym == 2'b10 || (prev_sym == 2'b01 && sym == 2'b11) ||
             (prev_sym == 2'b11 && sym == 2'b01)) mlt_bad++;
         prev_sym = sym;
         nbits++;
         if (nbits > 20 && nbits <= 60) begin
            hist = {hist[9:0], ~b};
         end else if (nbits > 60) begin
            key  = hist[10] ^ hist[8];
            hist = {hist[9:0], key};
            p    = b ^ key;
            if (nbits <= 400 && p != 1'b1) idle_bad++;
            if (nbits == 400) chk(idle_bad == 0, "R6", "idle descrambles to ones", idle_bad, 0);
            if (mstate == 0) begin
               win = {win[8:0], p};
               if (win == {G_J, G_K}) begin
                  frames_seen++;
                  data_in_frame = 0;
                  if (exp_q.size() < 2) begin
                     chk(1'b0, "R2", "delimiter with empty scoreboard", 0, 2);
                  end else begin
                     e = exp_q.pop_front();
                     chk(e == G_J, "R2", "start group J", G_J, e);
                     e = exp_q.pop_front();
                     chk(e == G_K, "R2", "start group K", G_K, e);
                  end
                  mstate = 1;
                  bcnt   = 0;
               end
            end else begin
               acc = {acc[3:0], p};
               bcnt++;
               if (bcnt == 5) begin
                  bcnt = 0;
                  if (mstate == 2) begin
                     chk(acc == G_I, "R5", "idle after R", acc, G_I);
                     mstate = 0;
                     win    = '1;
                  end else if (exp_q.size() == 0) begin
                     chk(1'b0, "R4", "group with empty scoreboard", acc, 0);
                     mstate = 0;
                     win    = '1;
                  end else begin
                     e = exp_q.pop_front();
                     if (e == G_T || e == G_R)
                        chk(acc == e, "R3", "end delimiter", acc, e);
                     else begin
                        chk(acc == e, "R4", "data group", acc, e);
                        data_in_frame++;
                     end
                     if (e == G_R) begin
                        if (data_in_frame == 0) empty_frames++;
                        mstate = 2;
                     end
                  end
               end
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic drive_nib(input logic en, input logic [3:0] d);
      @(posedge tx_clk);
      @(negedge clk_sym);
      tx_en = en;
      txd   = d;
   endtask

   task automatic send_frame(input int n, input logic [3:0] p0, input logic [3:0] p1,
                             input int start, input int step);
      exp_q.push_back(G_J);
      exp_q.push_back(G_K);
      for (int i = 0; i < n; i++) exp_q.push_back(code_tab[(start + i*step) & 15]);
      exp_q.push_back(G_T);
      exp_q.push_back(G_R);
      drive_nib(1'b1, p0);
      drive_nib(1'b1, p1);
      for (int i = 0; i < n; i++) drive_nib(1'b1, 4'((start + i*step) & 15));
      for (int i = 0; i < 4; i++) drive_nib(1'b0, 4'h0);
   endtask

   // ---------------- sequence ----------------
   initial begin
      int hi, lo;
      repeat (4) @(negedge clk_sym);
      chk(sym == 2'b00, "R8", "sym in reset", sym, 0);
      chk(tx_clk == 1'b1, "R8", "tx_clk in reset", tx_clk, 1);
      rst_n = 1'b1;

      // R1: tx_clk shape
      @(posedge tx_clk);
      @(negedge clk_sym);
      hi = 0; lo = 0;
      while (tx_clk)  begin hi++; @(negedge clk_sym); end
      while (!tx_clk) begin lo++; @(negedge clk_sym); end
      chk(hi == 2, "R1", "tx_clk high cycles", hi, 2);
      chk(lo == 3, "R1", "tx_clk low cycles", lo, 3);

      repeat (600) @(negedge clk_sym);

      send_frame(16, 4'h5, 4'h5, 0, 1);   // R4: all sixteen codes
      send_frame(0, 4'hF, 4'h0, 0, 1);    // R9 and R2: payload-free, odd preamble
      send_frame(5, 4'h0, 4'hA, 10, 11);  // R2: preamble values ignored
      send_frame(8, 4'h5, 4'hD, 15, 7);

      repeat (300) @(negedge clk_sym);
      chk(frames_seen == 4, "R2", "frames found by delimiter", frames_seen, 4);
      chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
      chk(empty_frames == 1, "R9", "payload-free frame J K T R", empty_frames, 1);
      chk(mlt_bad == 0, "R7", "illegal MLT-3 steps", mlt_bad, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule